// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number and an offset inside that segment, into a physical address. It keeps a small table with one entry per segment. Each entry holds a base address, a length limit, three permission bits (read, write and execute) and a valid flag. The segment number indexes the table directly. The offset is checked against the entry's limit and the access type against its permissions. On success the physical address is the base plus the offset.

Software fills the table through a single write port, one entry per cycle. Requests arrive with a valid strobe, the segment, the offset and an access type. Each request gets a registered response one cycle later. The response carries either a physical address or a fault code. Translation is fully pipelined, so one request can be accepted every cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset deassertion every table entry is invalid and `rsp_valid_o` is 0.
- R2: A request presented with `req_valid_i` high in cycle N produces `rsp_valid_o` high in cycle N+1. Without a request, `rsp_valid_o` is low in the next cycle.
- R3: For an allowed access, `rsp_paddr_o` equals the base of entry `req_seg_i` plus the offset, modulo 2^PA_W, and `rsp_fault_o` is 0 (none).
- R4: A request to an entry whose valid flag is clear returns fault code 3 (no segment).
- R5: An offset greater than or equal to the entry's limit returns fault code 1 (bounds). A limit of 0 makes every offset fault.
- R6: An access whose permission bit is clear returns fault code 2 (protection). Access codes are 0 read, 1 write, 2 execute, with permission bits [0] read, [1] write, [2] execute. Access code 3 is never allowed.
- R7: Fault priority is no-segment first, then bounds, then protection.
- R8: A table write and a request to the same entry in the same cycle translate with the entry's old contents. The new contents apply from the next cycle on.
- R9: Whenever `rsp_fault_o` is nonzero, or `rsp_valid_o` is low, `rsp_paddr_o` is 0. When `rsp_valid_o` is low, `rsp_fault_o` is 0.
- R10: Writing an entry with `cfg_valid_i` low invalidates it, and later requests to it fault with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_seg_i | input | 3 | Entry to write |
| cfg_valid_i | input | 1 | Valid flag written to the entry |
| cfg_base_i | input | 16 | Base physical address |
| cfg_limit_i | input | 13 | Segment length (0 to 4096) |
| cfg_perm_i | input | 3 | Permissions: [0] read, [1] write, [2] execute |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | 3 | Segment number |
| req_off_i | input | 12 | Offset inside the segment |
| req_acc_i | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid_o | output | 1 | Response valid |
| rsp_paddr_o | output | 16 | Physical address, 0 on fault |
| rsp_fault_o | output | 2 | 0 none, 1 bounds, 2 protection, 3 no segment |

## Verification
The bench targets the offset that equals the limit exactly, where an off-by-one compare would let one illegal access through. It uses a segment whose limit is 0, which must fault on every offset. It uses a base near the top of the address space, so the add must wrap and not saturate or widen. Requests that break both the bounds and the permissions show whether the design reports the wrong fault when priority is inverted. Writes and requests to the same entry in the same cycle catch a design that forwards the new entry too early. Invalidating an entry catches a design that keeps translating through a stale entry.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BOUNDS = 2'd1,
    FLT_PROT   = 2'd2,
    FLT_NOSEG  = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int unsigned PERM_W = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEGS  = 8,
  parameter int unsigned PA_W  = 16,
  parameter int unsigned LIM_W = 13,
  localparam int unsigned SEG_W = $clog2(SEGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEG_W-1:0]  wseg_i,
  input  logic              wvalid_i,
  input  logic [PA_W-1:0]   wbase_i,
  input  logic [LIM_W-1:0]  wlimit_i,
  input  logic [PERM_W-1:0] wperm_i,
  input  logic [SEG_W-1:0]  rseg_i,
  output logic              rvalid_o,
  output logic [PA_W-1:0]   rbase_o,
  output logic [LIM_W-1:0]  rlimit_o,
  output logic [PERM_W-1:0] rperm_o
);
  logic [SEGS-1:0]   valid_q;
  logic [PA_W-1:0]   base_q  [SEGS];
  logic [LIM_W-1:0]  limit_q [SEGS];
  logic [PERM_W-1:0] perm_q  [SEGS];

  for (genvar g = 0; g < SEGS; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (wseg_i == SEG_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        perm_q[g]  <= '0;
      end else if (hit) begin
        valid_q[g] <= wvalid_i;
        base_q[g]  <= wbase_i;
        limit_q[g] <= wlimit_i;
        perm_q[g]  <= wperm_i;
      end
    end
  end

  // read sees pre-edge contents: same-cycle write is not forwarded
  assign rvalid_o = valid_q[rseg_i];
  assign rbase_o  = base_q[rseg_i];
  assign rlimit_o = limit_q[rseg_i];
  assign rperm_o  = perm_q[rseg_i];

  // R10
  wr_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(wseg_i)] == $past(wvalid_i)));

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (valid_q == '0));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int unsigned PA_W  = 16,
  parameter int unsigned OFF_W = 12,
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input  logic              ent_valid_i,
  input  logic [PA_W-1:0]   ent_base_i,
  input  logic [LIM_W-1:0]  ent_limit_i,
  input  logic [PERM_W-1:0] ent_perm_i,
  input  logic [OFF_W-1:0]  off_i,
  input  acc_e              acc_i,
  output fault_e            fault_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic perm_ok;
  logic in_bounds;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm_ok = ent_perm_i[0];
      ACC_WRITE: perm_ok = ent_perm_i[1];
      ACC_EXEC:  perm_ok = ent_perm_i[2];
      default:   perm_ok = 1'b0;
    endcase
  end

  assign in_bounds = {1'b0, off_i} < ent_limit_i;

  always_comb begin
    if (!ent_valid_i)     fault_o = FLT_NOSEG;
    else if (!in_bounds)  fault_o = FLT_BOUNDS;
    else if (!perm_ok)    fault_o = FLT_PROT;
    else                  fault_o = FLT_NONE;
  end

  // add runs alongside the checks; masked on fault
  assign paddr_o = (fault_o == FLT_NONE) ? ent_base_i + PA_W'(off_i) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned SEGS  = 8,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 16,
  localparam int unsigned SEG_W = $clog2(SEGS),
  localparam int unsigned LIM_W = OFF_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [SEG_W-1:0]  cfg_seg_i,
  input  logic              cfg_valid_i,
  input  logic [PA_W-1:0]   cfg_base_i,
  input  logic [LIM_W-1:0]  cfg_limit_i,
  input  logic [PERM_W-1:0] cfg_perm_i,
  input  logic              req_valid_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic [OFF_W-1:0]  req_off_i,
  input  logic [1:0]        req_acc_i,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [1:0]        rsp_fault_o
);
  logic              ent_valid;
  logic [PA_W-1:0]   ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic [PERM_W-1:0] ent_perm;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_paddr;

  seg_table #(.SEGS(SEGS), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wseg_i   (cfg_seg_i),
    .wvalid_i (cfg_valid_i),
    .wbase_i  (cfg_base_i),
    .wlimit_i (cfg_limit_i),
    .wperm_i  (cfg_perm_i),
    .rseg_i   (req_seg_i),
    .rvalid_o (ent_valid),
    .rbase_o  (ent_base),
    .rlimit_o (ent_limit),
    .rperm_o  (ent_perm)
  );

  seg_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
    .ent_valid_i (ent_valid),
    .ent_base_i  (ent_base),
    .ent_limit_i (ent_limit),
    .ent_perm_i  (ent_perm),
    .off_i       (req_off_i),
    .acc_i       (acc_e'(req_acc_i)),
    .fault_o     (chk_fault),
    .paddr_o     (chk_paddr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= FLT_NONE;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? chk_paddr : '0;
      rsp_fault_o <= req_valid_i ? chk_fault : FLT_NONE;
    end
  end

  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  // R2
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  // R9
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o != FLT_NONE || !rsp_valid_o) |-> (rsp_paddr_o == '0));

  // R9
  idle_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (rsp_fault_o == FLT_NONE));

  // R6
  rsvd_denied_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_acc_i == 2'd3) |=> (rsp_fault_o != FLT_NONE));

  // R4
  noseg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !ent_valid) |=> (rsp_fault_o == FLT_NOSEG));
endmodule

// File: tb/seg_xlate_test.sv
module seg_xlate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_seg = '0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_base = '0;
  logic [12:0] cfg_limit = '0;
  logic [2:0]  cfg_perm = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [11:0] req_off = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_seg_i(cfg_seg), .cfg_valid_i(cfg_valid),
    .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit), .cfg_perm_i(cfg_perm),
    .req_valid_i(req_valid), .req_seg_i(req_seg), .req_off_i(req_off), .req_acc_i(req_acc),
    .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model
  bit m_valid [8];
  int m_base  [8];
  int m_limit [8];
  int m_perm  [8];
  bit exp_valid = 0;
  int exp_paddr = 0;
  int exp_fault = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_valid[i] = 0;
      exp_valid = 0; exp_paddr = 0; exp_fault = 0;
    end else begin
      exp_valid = req_valid;
      exp_paddr = 0;
      exp_fault = 0;
      if (req_valid) begin
        int s;
        s = int'(req_seg);
        if (!m_valid[s]) exp_fault = 3;
        else if (int'(req_off) >= m_limit[s]) exp_fault = 1;
        else if (req_acc == 2'd3 || ((m_perm[s] >> int'(req_acc)) & 1) == 0) exp_fault = 2;
        else exp_paddr = (m_base[s] + int'(req_off)) % 65536;
      end
      if (cfg_we) begin
        m_valid[cfg_seg] = cfg_valid;
        m_base[cfg_seg]  = int'(cfg_base);
        m_limit[cfg_seg] = int'(cfg_limit);
        m_perm[cfg_seg]  = int'(cfg_perm);
      end
    end
  end

  function automatic string fault_tag(int f);
    case (f)
      1: return "R5";
      2: return "R6";
      3: return "R4";
      default: return "R3";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rsp_valid !== exp_valid) begin
        failures++;
        $display("FAIL %s/R2 valid act=%0d exp=%0d", tag, rsp_valid, exp_valid);
      end
      checks++;
      if (rsp_fault !== 2'(exp_fault)) begin
        failures++;
        $display("FAIL %s/%s fault act=%0d exp=%0d", tag, fault_tag(exp_fault), rsp_fault, exp_fault);
      end
      checks++;
      if (rsp_paddr !== 16'(exp_paddr)) begin
        failures++;
        $display("FAIL %s/%s paddr act=%h exp=%h", tag,
                 (exp_fault != 0 || !exp_valid) ? "R9" : "R3", rsp_paddr, 16'(exp_paddr));
      end
    end
  end

  task automatic idle();
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic wr(input int s, input bit v, input int b, input int l, input int p);
    cfg_we = 1; cfg_seg = 3'(s); cfg_valid = v;
    cfg_base = 16'(b); cfg_limit = 13'(l); cfg_perm = 3'(p);
  endtask

  task automatic rq(input int s, input int o, input int a);
    req_valid = 1; req_seg = 3'(s); req_off = 12'(o); req_acc = 2'(a);
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: every entry invalid after reset
    tag = "R1";
    for (int s = 0; s < 8; s++) begin rq(s, 0, 0); tick(); end
    tick();
    // R3: program table; seg1 code (read+exec), seg5 limit 0, seg7 wraps
    tag = "R3";
    for (int s = 0; s < 8; s++) begin
      wr(s, 1, 16'h1000 * s + 16'h0123, 16'h100 * (s + 1), (s == 1) ? 5 : 7);
      tick();
    end
    wr(5, 1, 16'h5000, 0, 7); tick();
    wr(7, 1, 16'hFF00, 16'h1000, 7); tick();
    for (int s = 0; s < 8; s++) begin
      rq(s, 0, 0); tick();
      rq(s, 16'h100 * (s + 1) - 1, 2); tick();
    end
    rq(7, 16'h0FFF, 1); tick();
    // R5: offset equal to limit, and limit zero
    tag = "R5";
    for (int s = 0; s < 5; s++) begin rq(s, 16'h100 * (s + 1), 0); tick(); end
    rq(5, 0, 0); tick();
    rq(7, 16'hFFF, 0); tick();
    // R6: write to code segment, reserved access
    tag = "R6";
    rq(1, 4, 1); tick();
    rq(1, 4, 2); tick();
    rq(0, 4, 3); tick();
    wr(4, 1, 16'h4000, 16'h40, 0); tick();
    for (int a = 0; a < 4; a++) begin rq(4, 1, a); tick(); end
    // R7: bounds beats protection, no-segment beats both
    tag = "R7";
    rq(1, 16'h300, 1); tick();
    wr(6, 0, 0, 0, 0); tick();
    rq(6, 16'hFFF, 3); tick();
    // R8: write and request in the same cycle
    tag = "R8";
    wr(2, 1, 16'hA000, 16'h10, 1); rq(2, 16'h50, 0); tick();
    rq(2, 16'h50, 0); tick();
    rq(2, 16'h5, 0); tick();
    rq(2, 16'h5, 1); tick();
    // R10: invalidate an entry
    tag = "R10";
    wr(3, 0, 16'h3333, 16'h400, 7); rq(3, 1, 0); tick();
    rq(3, 1, 0); tick();
    // R2: idle gaps
    tag = "R2";
    tick(); rq(0, 1, 0); tick(); tick();
    // random mix
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        wr($urandom_range(0, 7), $urandom_range(0, 5) != 0, $urandom_range(0, 65535),
           $urandom_range(0, 4096), $urandom_range(0, 7));
      if ($urandom_range(0, 4) != 0)
        rq($urandom_range(0, 7), $urandom_range(0, 4095), $urandom_range(0, 3));
      tick();
    end
    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule